// File: doc/BRIEF.md
# Segment Access Protection Checker

This block decides, in a single combinational pass, whether one memory access made through a segment must raise a general protection fault. It takes the current operating mode (protected mode on or off, long mode active, code segment running in 64-bit form), the segment being used (its index, selector value, access attributes, base and limit), and the access itself (offset, size code, and whether it is a write or an instruction fetch). It returns a fault flag and a reason code.

The checks run in a fixed order: mode bypass, then the null selector, then the write and read permission checks, then the limit check. Only the first failing check is reported. Permission checks and the expand-down attribute apply only to segment indices inside a parameterised data-segment window. Expand-down segments whose limit lies below their base use a separate rule from the usual upper-bound check.

The block sits in front of address generation. Loading descriptors, adding the base and page translation all happen elsewhere.

Top module: `seg_guard_check`

## Requirements
- R1: When `prot_en` is 0 the block never faults: `gp_fault` is 0 and `fault_why` is 0, whatever the other inputs are.
- R2: When `long_act` and `cs_wide` are both 1 the block never faults. When only one of them is 1, the checks run as usual.
- R3: When checks run and `seg_sel` is zero, the result is reason code 1 (null selector). This takes priority over every other check.
- R4: For a segment index inside the data window [DATA_LO, DATA_HI], a write (`acc_write`=1) to a segment with `attr_wr`=0 gives reason code 2.
- R5: For a segment index inside the data window, an access that is neither a write nor a fetch, to a segment with `attr_rd`=0, gives reason code 3. An instruction fetch is never refused for lack of read permission.
- R6: For a segment index outside the data window, both permission checks are skipped and `attr_xd` is ignored, so the segment is treated as expand-up.
- R7: For an expand-up segment, and for an expand-down segment whose limit is not below its base, the access gives reason code 4 exactly when its last byte address (offset + size - 1) is greater than the limit. The sum is formed one bit wider than the address, so it never wraps.
- R8: For an expand-down segment whose limit is below its base, the access gives reason code 4 exactly when its last byte address is greater than the limit and its offset is below the base.
- R9: Reason codes are: 0 none, 1 null selector, 2 write-protect, 3 read-protect, 4 limit. `gp_fault` is 1 exactly when the code is not 0. When several checks fail, the lowest numbered failing code is reported.
- R10: The access size code `acc_size` maps 0, 1, 2, 3 to 1, 2, 4, 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prot_en | input | 1 | Protected mode enabled |
| long_act | input | 1 | Long mode active |
| cs_wide | input | 1 | Code segment runs in 64-bit form |
| seg_idx | input | IDX_W | Segment index used by the access |
| seg_sel | input | SEL_W | Selector value held for that segment |
| attr_rd | input | 1 | Segment readable |
| attr_wr | input | 1 | Segment writable |
| attr_xd | input | 1 | Segment grows downward |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| acc_off | input | ADDR_W | Access offset (first byte) |
| acc_size | input | 2 | Size code: 1, 2, 4 or 8 bytes |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| gp_fault | output | 1 | General protection fault raised |
| fault_why | output | 3 | Reason code of the first failing check |

## Verification
The assertions check, on every input change, that the mode bypass never lets a fault through, that a zero selector always yields the null reason once checks are on, that the fault flag agrees with the reason code, that a permission fault only appears with the matching access kind and attribute, and that the widened end address never wraps. Whether the exact boundary between a passing and a failing offset sits where the requirements put it, for every size code, base and limit (including an expand-down limit below its base), only shows up in the bench's exhaustive sweeps. The same holds for the priority among several simultaneous failures, which the bench checks against its own arithmetic.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    typedef enum logic [2:0] {
        WHY_NONE     = 3'd0,
        WHY_NULL_SEL = 3'd1,
        WHY_WR_PROT  = 3'd2,
        WHY_RD_PROT  = 3'd3,
        WHY_LIMIT    = 3'd4
    } fault_why_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic xd;
    } seg_attr_t;

    typedef struct packed {
        logic is_write;
        logic is_fetch;
    } acc_kind_t;

    // Size code to byte count: 0->1, 1->2, 2->4, 3->8 (R10)
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/seg_mode_gate.sv
module seg_mode_gate (
    input  logic prot_en,
    input  logic long_act,
    input  logic cs_wide,
    output logic checks_on
);
    logic wide_mode;

    always_comb begin
        wide_mode = long_act & cs_wide;
        checks_on = prot_en & ~wide_mode;
    end
endmodule

// File: rtl/seg_attr_check.sv
module seg_attr_check
    import seg_guard_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int DATA_LO = 0,
    parameter int DATA_HI = 5
) (
    input  logic [IDX_W-1:0] seg_idx,
    input  seg_attr_t        attr,
    input  acc_kind_t        kind,
    output logic             in_data,
    output logic             wr_viol,
    output logic             rd_viol
);
    localparam int NUM_IDX = 1 << IDX_W;

    logic [NUM_IDX-1:0] data_mask;

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_mask
        assign data_mask[i] = (i >= DATA_LO) && (i <= DATA_HI);
    end

    always_comb begin
        in_data = data_mask[seg_idx];
        wr_viol = in_data & kind.is_write & ~attr.wr;
        rd_viol = in_data & ~kind.is_write & ~kind.is_fetch & ~attr.rd;
    end

    always_comb begin
        if (wr_viol) begin
            a_r4_wr_needs_write: assert (kind.is_write && !attr.wr)
                else $error("write-protect raised without a write to a read-only segment");
        end
        if (rd_viol) begin
            a_r5_rd_not_fetch: assert (!kind.is_fetch && !kind.is_write)
                else $error("read-protect raised for a fetch or a write");
        end
    end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [ADDR_W-1:0] acc_off,
    input  logic [1:0]        acc_size,
    input  logic              grows_down,
    output logic              lim_viol
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] last_byte;
    logic [EXT_W-1:0] limit_ext;
    logic [EXT_W-1:0] span_ext;
    logic             over_top;
    logic             below_base;
    logic             split_seg;

    always_comb begin
        span_ext   = EXT_W'(size_bytes(acc_size));
        last_byte  = {1'b0, acc_off} + span_ext - EXT_W'(1);
        limit_ext  = {1'b0, seg_limit};
        over_top   = last_byte > limit_ext;
        below_base = acc_off < seg_base;
        split_seg  = grows_down & (seg_limit < seg_base);
        lim_viol   = split_seg ? (over_top & below_base) : over_top;
    end

    always_comb begin
        a_r7_no_wrap: assert (last_byte >= {1'b0, acc_off})
            else $error("widened end address wrapped");
    end
endmodule

// File: rtl/seg_guard_check.sv
module seg_guard_check
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 16,
    parameter int IDX_W   = 3,
    parameter int DATA_LO = 0,
    parameter int DATA_HI = 5
) (
    input  logic              prot_en,
    input  logic              long_act,
    input  logic              cs_wide,
    input  logic [IDX_W-1:0]  seg_idx,
    input  logic [SEL_W-1:0]  seg_sel,
    input  logic              attr_rd,
    input  logic              attr_wr,
    input  logic              attr_xd,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [ADDR_W-1:0] acc_off,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic              acc_fetch,
    output logic              gp_fault,
    output logic [2:0]        fault_why
);
    seg_attr_t  attr;
    acc_kind_t  kind;
    fault_why_e why;
    logic       checks_on;
    logic       in_data;
    logic       wr_viol;
    logic       rd_viol;
    logic       lim_viol;
    logic       null_sel;
    logic       grows_down;

    always_comb begin
        attr       = '{rd: attr_rd, wr: attr_wr, xd: attr_xd};
        kind       = '{is_write: acc_write, is_fetch: acc_fetch};
        null_sel   = (seg_sel == '0);
        grows_down = in_data & attr.xd;
    end

    seg_mode_gate u_mode (
        .prot_en   (prot_en),
        .long_act  (long_act),
        .cs_wide   (cs_wide),
        .checks_on (checks_on)
    );

    seg_attr_check #(
        .IDX_W   (IDX_W),
        .DATA_LO (DATA_LO),
        .DATA_HI (DATA_HI)
    ) u_attr (
        .seg_idx (seg_idx),
        .attr    (attr),
        .kind    (kind),
        .in_data (in_data),
        .wr_viol (wr_viol),
        .rd_viol (rd_viol)
    );

    seg_limit_check #(
        .ADDR_W (ADDR_W)
    ) u_lim (
        .seg_base   (seg_base),
        .seg_limit  (seg_limit),
        .acc_off    (acc_off),
        .acc_size   (acc_size),
        .grows_down (grows_down),
        .lim_viol   (lim_viol)
    );

    // First failing check wins (R9)
    always_comb begin
        why = WHY_NONE;
        if (checks_on) begin
            if (null_sel)      why = WHY_NULL_SEL;
            else if (wr_viol)  why = WHY_WR_PROT;
            else if (rd_viol)  why = WHY_RD_PROT;
            else if (lim_viol) why = WHY_LIMIT;
        end
        fault_why = why;
        gp_fault  = (why != WHY_NONE);
    end

    always_comb begin
        if (!prot_en || (long_act && cs_wide)) begin
            a_r1_r2_bypass: assert (!gp_fault && fault_why == 3'd0)
                else $error("fault raised while checks are bypassed");
        end
        if (prot_en && !(long_act && cs_wide) && seg_sel == '0) begin
            a_r3_null_first: assert (fault_why == 3'd1)
                else $error("zero selector not reported as null");
        end
        a_r9_flag_matches: assert (gp_fault == (fault_why != 3'd0))
            else $error("fault flag disagrees with reason code");
        a_r9_code_range: assert (fault_why <= 3'd4)
            else $error("reason code out of range");
    end
endmodule

// File: tb/seg_guard_check_test.sv
module seg_guard_check_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int SW         = 4;
    localparam int IW         = 3;
    localparam int LO         = 0;
    localparam int HI         = 5;
    localparam int WD_CYCLES  = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prot_en, long_act, cs_wide;
    logic [IW-1:0] seg_idx;
    logic [SW-1:0] seg_sel;
    logic          attr_rd, attr_wr, attr_xd;
    logic [AW-1:0] seg_base, seg_limit, acc_off;
    logic [1:0]    acc_size;
    logic          acc_write, acc_fetch;
    logic          gp_fault;
    logic [2:0]    fault_why;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_guard_check #(
        .ADDR_W (AW), .SEL_W (SW), .IDX_W (IW), .DATA_LO (LO), .DATA_HI (HI)
    ) uut (
        .prot_en (prot_en), .long_act (long_act), .cs_wide (cs_wide),
        .seg_idx (seg_idx), .seg_sel (seg_sel),
        .attr_rd (attr_rd), .attr_wr (attr_wr), .attr_xd (attr_xd),
        .seg_base (seg_base), .seg_limit (seg_limit), .acc_off (acc_off),
        .acc_size (acc_size), .acc_write (acc_write), .acc_fetch (acc_fetch),
        .gp_fault (gp_fault), .fault_why (fault_why)
    );

    function automatic int model(int pe, int la, int cw, int idx, int sel,
                                 int rd, int wr, int xd, int base, int lim,
                                 int off, int sz, int isw, int isf);
        int last;
        bit data;
        bit over;
        if (pe == 0 || (la == 1 && cw == 1)) return 0;
        if (sel == 0) return 1;
        data = (idx >= LO) && (idx <= HI);
        if (data && isw == 1 && wr == 0) return 2;
        if (data && isw == 0 && isf == 0 && rd == 0) return 3;
        last = off + (1 << sz) - 1;
        over = last > lim;
        if (data && xd == 1 && lim < base) begin
            if (over && off < base) return 4;
            return 0;
        end
        if (over) return 4;
        return 0;
    endfunction

    function automatic string tag_of(int exp_code, int pe, int la, int cw,
                                     int idx, int xd, int base, int lim);
        if (pe == 0) return "R1";
        if (la == 1 && cw == 1) return "R2";
        case (exp_code)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: ;
        endcase
        if (idx < LO || idx > HI) return "R6";
        if (xd == 1 && lim < base) return "R8";
        return "R7";
    endfunction

    task automatic apply_check(int pe, int la, int cw, int idx, int sel,
                               int rd, int wr, int xd, int base, int lim,
                               int off, int sz, int isw, int isf, string req);
        int exp_code;
        prot_en = pe[0]; long_act = la[0]; cs_wide = cw[0];
        seg_idx = idx[IW-1:0]; seg_sel = sel[SW-1:0];
        attr_rd = rd[0]; attr_wr = wr[0]; attr_xd = xd[0];
        seg_base = base[AW-1:0]; seg_limit = lim[AW-1:0]; acc_off = off[AW-1:0];
        acc_size = sz[1:0]; acc_write = isw[0]; acc_fetch = isf[0];
        #1;
        exp_code = model(pe, la, cw, idx, sel, rd, wr, xd, base, lim, off, sz, isw, isf);
        if (req == "") req = tag_of(exp_code, pe, la, cw, idx, xd, base, lim);
        checks++;
        if (int'(fault_why) != exp_code || gp_fault != (exp_code != 0)) begin
            failures++;
            $display("FAIL %s: why=%0d fault=%0b expected why=%0d fault=%0b (off=%0d sz=%0d base=%0d lim=%0d idx=%0d)",
                     req, fault_why, gp_fault, exp_code, exp_code != 0,
                     off, sz, base, lim, idx);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int bases [5] = '{0, 5, 20, 40, 63};
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Idle state after reset: protection off, nothing faults (R1)
        apply_check(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");

        // Directed boundary checks
        apply_check(1, 0, 0, 1, 3, 1, 1, 0, 0, 30, 30, 0, 0, 0, "R7");  // last byte on limit
        apply_check(1, 0, 0, 1, 3, 1, 1, 0, 0, 30, 30, 1, 0, 0, "R7");  // spills one byte
        apply_check(1, 0, 0, 1, 3, 1, 1, 0, 0, 63, 56, 3, 0, 0, "R10"); // 8 bytes to top
        apply_check(1, 0, 0, 1, 3, 1, 1, 0, 0, 63, 57, 3, 0, 0, "R7");  // wider sum, no wrap
        apply_check(1, 0, 0, 1, 3, 1, 1, 0, 0, 3, 0, 2, 0, 0, "R10");   // 4 bytes fit
        apply_check(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 60, 3, 1, 0, "R3");   // all fail, null wins
        apply_check(1, 0, 0, 1, 5, 0, 0, 0, 0, 0, 60, 3, 1, 0, "R9");   // write beats limit
        apply_check(1, 0, 0, 1, 5, 0, 1, 0, 0, 0, 60, 3, 0, 1, "R5");   // fetch ignores rd
        apply_check(1, 0, 0, 7, 5, 0, 0, 1, 40, 10, 50, 0, 1, 0, "R6"); // outside window
        apply_check(1, 0, 0, 2, 5, 1, 1, 1, 40, 10, 20, 0, 0, 0, "R8"); // hole below base
        apply_check(1, 0, 0, 2, 5, 1, 1, 1, 40, 10, 45, 0, 0, 0, "R8"); // at/above base ok
        apply_check(1, 1, 0, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R2");    // one flag only
        apply_check(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 60, 3, 1, 0, "R2");   // full bypass

        // Exhaustive limit sweep over offset, size, limit, chosen bases, both growth directions
        for (int xd = 0; xd < 2; xd++)
            for (int b = 0; b < 5; b++)
                for (int lim = 0; lim < 64; lim++)
                    for (int off = 0; off < 64; off++)
                        for (int sz = 0; sz < 4; sz++)
                            apply_check(1, 0, 0, 2, 9, 1, 1, xd, bases[b], lim, off, sz, 0, 0, "");

        // Mode, selector, window and permission sweep
        for (int pe = 0; pe < 2; pe++)
            for (int la = 0; la < 2; la++)
                for (int cw = 0; cw < 2; cw++)
                    for (int idx = 0; idx < 8; idx++)
                        for (int s = 0; s < 2; s++)
                            for (int at = 0; at < 8; at++)
                                for (int k = 0; k < 4; k++)
                                    for (int o = 0; o < 2; o++)
                                        apply_check(pe, la, cw, idx, s * 3, at & 1, (at >> 1) & 1,
                                                    (at >> 2) & 1, 40, 10, o ? 50 : 20, 1,
                                                    k & 1, (k >> 1) & 1, "");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule